// File: doc/BRIEF.md
# Staged Panel Power Sequencer

This block brings an LCD panel up by raising its power and control lines one after another in a fixed order: panel supply, video data enable, backlight supply, backlight PWM, and backlight enable. Between these steps it enforces a programmable dwell, given in milliseconds and counted on a one-microsecond tick from the rest of the chip. A start request arms the sequence. After that, each poll strobe performs at most one step once the current dwell has expired. A poll made with the wait-mode bit set instead runs every remaining step by itself, still honouring each dwell, until the panel is fully up.

Each output has its own enable bit, so boards that lack a given line can skip it. A skipped step still advances the stage and still imposes its dwell, which keeps the timing of the remaining lines the same on every board. The PWM step switches on the backlight modulator with a fixed duty code. The PWM generator itself, pin multiplexing and power-down are handled elsewhere.

Top module: `panel_seq`

## Requirements
- R1: A synchronous reset (rst_i high at a clock edge) sets stage_o to 0, clears done_o and drives panel_vdd_o, data_en_o, bl_vdd_o, pwm_en_o, bl_en_o and pwm_duty_o to zero.
- R2: In stage 0 polls are ignored. A start_i pulse moves stage_o from 0 to 1 at the clock edge that samples it.
- R3: Stage codes are 1 panel supply, 2 data enable, 3 backlight supply, 4 PWM, 5 backlight enable, 6 done. In stages 1 to 5, a poll sampled while no dwell is pending performs that stage: at the same edge the stage's output rises (if enabled) and stage_o increases by exactly one.
- R4: A poll sampled while a dwell is still pending changes nothing.
- R5: The stage performed from code 1, 2, 3 or 4 loads a dwell of delay_vdd_ms_i, delay_data_ms_i, delay_blvdd_ms_i or delay_pwm_ms_i respectively, times US_PER_MS ticks. With us_tick_i high every cycle and a stage performed at edge E with dwell D*US_PER_MS, a poll at edge E+D*US_PER_MS is ignored and a poll at the following edge is accepted.
- R6: en_mask_i bit 0 gates panel_vdd_o, bit 1 data_en_o, bit 2 bl_vdd_o, bit 3 pwm_en_o, bit 4 bl_en_o. With a bit clear, the step keeps its output low but still advances the stage and still loads its dwell.
- R7: When the PWM stage is performed with its bit enabled, pwm_en_o rises and pwm_duty_o becomes 0xDF. Until then pwm_duty_o is 0.
- R8: A poll with wait_i high runs all remaining stages without further polls, each at the first edge after its dwell expires, until done.
- R9: Performing stage 5 sets stage_o to 6 and raises done_o. After that, start_i and polls in either mode change nothing.
- R10: Once raised, an output stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| us_tick_i | input | 1 | One-cycle pulse per microsecond |
| start_i | input | 1 | Arms the sequence from stage 0 |
| poll_i | input | 1 | Advance request |
| wait_i | input | 1 | With poll_i: run to completion |
| en_mask_i | input | 5 | Per-output enable bits |
| delay_vdd_ms_i | input | DLY_W | Dwell after panel supply (ms) |
| delay_data_ms_i | input | DLY_W | Dwell after data enable (ms) |
| delay_blvdd_ms_i | input | DLY_W | Dwell after backlight supply (ms) |
| delay_pwm_ms_i | input | DLY_W | Dwell after PWM enable (ms) |
| panel_vdd_o | output | 1 | Panel supply enable |
| data_en_o | output | 1 | Video data link enable |
| bl_vdd_o | output | 1 | Backlight supply enable |
| pwm_en_o | output | 1 | Backlight PWM enable |
| pwm_duty_o | output | 8 | Backlight PWM duty code |
| bl_en_o | output | 1 | Backlight enable |
| stage_o | output | 3 | Next stage to perform |
| done_o | output | 1 | Sequence complete |

## Verification
On every cycle the assertions check that the stage only ever moves forward by one, that leaving stage 0 requires a start request, that no step after a dwell-bearing stage happens while a dwell is pending, that the done state and raised outputs never fall back, and that the PWM enable never appears before the PWM step. Only the bench's scenarios can show the exact edge at which a dwell expires, the effect of each mask bit, the duty code, and the full timing of an unattended wait-mode run.

// File: rtl/panel_seq.sv
module panel_seq #(
  parameter int DLY_W = 8,
  parameter int US_PER_MS = 1000,
  parameter logic [7:0] PWM_DUTY = 8'hDF
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             us_tick_i,
  input  logic             start_i,
  input  logic             poll_i,
  input  logic             wait_i,
  input  logic [4:0]       en_mask_i,
  input  logic [DLY_W-1:0] delay_vdd_ms_i,
  input  logic [DLY_W-1:0] delay_data_ms_i,
  input  logic [DLY_W-1:0] delay_blvdd_ms_i,
  input  logic [DLY_W-1:0] delay_pwm_ms_i,
  output logic             panel_vdd_o,
  output logic             data_en_o,
  output logic             bl_vdd_o,
  output logic             pwm_en_o,
  output logic [7:0]       pwm_duty_o,
  output logic             bl_en_o,
  output logic [2:0]       stage_o,
  output logic             done_o
);

  localparam int CNT_W = DLY_W + $clog2(US_PER_MS) + 1;
  localparam logic [2:0] ST_IDLE = 3'd0;
  localparam logic [2:0] ST_FIRST = 3'd1;
  localparam logic [2:0] ST_LAST = 3'd5;
  localparam logic [2:0] ST_DONE = 3'd6;

  logic [2:0]       stage_q;
  logic [CNT_W-1:0] cnt_q;
  logic             run_q;
  logic [4:0]       out_q;

  logic             active, ready, fire;
  logic [DLY_W-1:0] dly_sel;
  logic [CNT_W-1:0] dwell;
  logic [4:0]       step_bit;

  assign active = (stage_q >= ST_FIRST) && (stage_q <= ST_LAST);
  assign ready  = (cnt_q == '0);
  assign fire   = active && ready && (poll_i || run_q);

  always_comb begin
    case (stage_q)
      3'd1:    dly_sel = delay_vdd_ms_i;
      3'd2:    dly_sel = delay_data_ms_i;
      3'd3:    dly_sel = delay_blvdd_ms_i;
      3'd4:    dly_sel = delay_pwm_ms_i;
      default: dly_sel = '0;
    endcase
  end

  assign dwell    = CNT_W'(dly_sel) * CNT_W'(US_PER_MS);
  assign step_bit = active ? (5'd1 << (stage_q - 3'd1)) : 5'd0;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      stage_q <= ST_IDLE;
      cnt_q   <= '0;
      run_q   <= 1'b0;
      out_q   <= '0;
    end else begin
      if (stage_q == ST_IDLE && start_i)
        stage_q <= ST_FIRST;
      if (active && poll_i && wait_i)
        run_q <= 1'b1;
      if (fire) begin
        stage_q <= stage_q + 3'd1;
        cnt_q   <= dwell;
        out_q   <= out_q | (step_bit & en_mask_i);
        if (stage_q == ST_LAST)
          run_q <= 1'b0;
      end else if (!ready && us_tick_i) begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign panel_vdd_o = out_q[0];
  assign data_en_o   = out_q[1];
  assign bl_vdd_o    = out_q[2];
  assign pwm_en_o    = out_q[3];
  assign bl_en_o     = out_q[4];
  assign pwm_duty_o  = out_q[3] ? PWM_DUTY : 8'h00;
  assign stage_o     = stage_q;
  assign done_o      = (stage_q == ST_DONE);

  a_r2_start_needed: assert property (@(posedge clk_i) disable iff (rst_i)
    ($past(stage_q) == ST_IDLE && stage_q == ST_FIRST) |-> $past(start_i));

  a_r3_single_step: assert property (@(posedge clk_i) disable iff (rst_i)
    !$stable(stage_q) |-> (stage_q == $past(stage_q) + 3'd1));

  a_r5_dwell_respected: assert property (@(posedge clk_i) disable iff (rst_i)
    (!$stable(stage_q) && $past(stage_q) >= 3'd2 && $past(stage_q) <= ST_LAST)
      |-> ($past(cnt_q) == '0));

  a_r9_done_sticky: assert property (@(posedge clk_i) disable iff (rst_i)
    done_o |=> (done_o && stage_q == ST_DONE));

  a_r10_outputs_hold: assert property (@(posedge clk_i) disable iff (rst_i)
    (out_q != '0) |=> ((out_q & $past(out_q)) == $past(out_q)));

  a_r7_pwm_order: assert property (@(posedge clk_i) disable iff (rst_i)
    pwm_en_o |-> (stage_q >= ST_LAST));

endmodule

// File: tb/panel_seq_test.sv
module panel_seq_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b1;
  logic       start = 1'b0;
  logic       poll = 1'b0;
  logic       waitm = 1'b0;
  logic [4:0] mask = 5'h1F;
  logic [7:0] d_vdd = 8'd0, d_data = 8'd0, d_blvdd = 8'd0, d_pwm = 8'd0;
  logic       panel_vdd, data_en, bl_vdd, pwm_en, bl_en, done;
  logic [7:0] duty;
  logic [2:0] stage;

  int tests = 0;
  int fails = 0;

  always #4 clk = ~clk;

  panel_seq uut (
    .clk_i(clk), .rst_i(rst), .us_tick_i(tick), .start_i(start),
    .poll_i(poll), .wait_i(waitm), .en_mask_i(mask),
    .delay_vdd_ms_i(d_vdd), .delay_data_ms_i(d_data),
    .delay_blvdd_ms_i(d_blvdd), .delay_pwm_ms_i(d_pwm),
    .panel_vdd_o(panel_vdd), .data_en_o(data_en), .bl_vdd_o(bl_vdd),
    .pwm_en_o(pwm_en), .pwm_duty_o(duty), .bl_en_o(bl_en),
    .stage_o(stage), .done_o(done)
  );

  function automatic logic [4:0] outs();
    return {bl_en, pwm_en, bl_vdd, data_en, panel_vdd};
  endfunction

  task automatic check(input string req, input int actual, input int expected);
    tests++;
    if (actual != expected) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
    end
  endtask

  task automatic poll_at(input int m);
    repeat (m - 1) @(negedge clk);
    poll = 1'b1;
    @(negedge clk);
    poll = 1'b0;
  endtask

  task automatic pulse_start();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 stage", stage, 0);
    check("R1 outputs", outs(), 0);
    check("R1 duty", duty, 0);
    check("R1 done", done, 0);
  endtask

  task automatic t_start_gate();
    poll_at(1);
    waitm = 1'b1;
    poll_at(1);
    waitm = 1'b0;
    check("R2 poll in idle", stage, 0);
    check("R2 idle outputs", outs(), 0);
    pulse_start();
    check("R2 start", stage, 1);
  endtask

  task automatic t_step();
    mask = 5'h1F; d_vdd = 8'd1; d_data = 8'd2; d_blvdd = 8'd1; d_pwm = 8'd1;
    do_reset();
    pulse_start();
    poll_at(1);
    check("R3 stage after panel", stage, 2);
    check("R3 panel only", outs(), 5'b00001);
    poll_at(1000);
    check("R4 early poll stage", stage, 2);
    check("R4 early poll data", data_en, 0);
    poll_at(1);
    check("R5 data stage", stage, 3);
    check("R5 data out", outs(), 5'b00011);
    poll_at(2000);
    check("R4 early poll blvdd", stage, 3);
    poll_at(1);
    check("R5 blvdd", outs(), 5'b00111);
    check("R7 duty before pwm", duty, 0);
    poll_at(1000);
    check("R4 early poll pwm", pwm_en, 0);
    poll_at(1);
    check("R7 pwm en", pwm_en, 1);
    check("R7 duty", duty, 8'hDF);
    poll_at(1000);
    check("R4 early poll blen", stage, 5);
    poll_at(1);
    check("R9 stage done", stage, 6);
    check("R9 done flag", done, 1);
    check("R3 all up", outs(), 5'b11111);
  endtask

  task automatic t_after_done();
    poll_at(1);
    pulse_start();
    waitm = 1'b1;
    poll_at(1);
    waitm = 1'b0;
    repeat (5) @(negedge clk);
    check("R9 stage held", stage, 6);
    check("R9 done held", done, 1);
    check("R10 outputs held", outs(), 5'b11111);
    check("R10 duty held", duty, 8'hDF);
  endtask

  task automatic t_mask();
    mask = 5'b10101; d_vdd = 8'd0; d_data = 8'd1; d_blvdd = 8'd0; d_pwm = 8'd0;
    do_reset();
    pulse_start();
    poll_at(1);
    check("R6 panel set", outs(), 5'b00001);
    poll_at(1);
    check("R6 skipped data stage", stage, 3);
    check("R6 data low", data_en, 0);
    poll_at(1000);
    check("R6 skipped keeps dwell", stage, 3);
    poll_at(1);
    check("R6 blvdd", outs(), 5'b00101);
    poll_at(1);
    check("R6 pwm skipped stage", stage, 5);
    check("R6 pwm low", pwm_en, 0);
    check("R7 duty idle", duty, 0);
    poll_at(1);
    check("R6 done", done, 1);
    check("R6 final outputs", outs(), 5'b10101);
  endtask

  task automatic t_wait();
    int n = 0;
    int n5 = 0;
    mask = 5'h1F; d_vdd = 8'd1; d_data = 8'd0; d_blvdd = 8'd2; d_pwm = 8'd1;
    do_reset();
    pulse_start();
    waitm = 1'b1;
    poll_at(1);
    waitm = 1'b0;
    check("R8 first step", stage, 2);
    while (!done && n < 6000) begin
      @(negedge clk);
      n++;
      if (stage == 3'd5 && n5 == 0) n5 = n;
    end
    check("R8 pwm reached at", n5, 3003);
    check("R8 done at", n, 4004);
    check("R8 outputs", outs(), 5'b11111);
  endtask

  task automatic t_reset_mid();
    mask = 5'h1F; d_vdd = 8'd1;
    do_reset();
    pulse_start();
    poll_at(1);
    do_reset();
    check("R1 reset mid stage", stage, 0);
    check("R1 reset mid outputs", outs(), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_start_gate();
    t_step();
    t_after_done();
    t_mask();
    t_wait();
    t_reset_mid();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule